// File: doc/BRIEF.md
# Converter Host Interface Controller

This block sits between a processor I/O bus and a converter that uses a start pulse and an end-of-conversion (EOC) handshake. Software programs a two-bit control register. One bit chooses what begins a conversion: either a write to a dedicated start port, or the rising edges of a slow periodic timer clock. The block shapes each timer edge into a start pulse one bus clock wide. The other bit chooses whether a finished conversion raises an interrupt request or is only visible for polling.

The timer clock and the EOC input arrive asynchronously, so each passes through a synchronizer before use. A rising EOC captures the converter's output word into a sample register and sets a sticky completion flag. A status port shows this flag together with the synchronized timer clock level. Reading the data port returns the captured sample and clears the flag, which also drops any pending interrupt.

The bus uses decoded selects with single-cycle read and write strobes, so it has no back-pressure. A read returns its data combinationally in the cycle of the strobe. The converter data is taken only on the EOC edge, so the converter must hold its output steady while EOC is high.

Top module: `cvi_host_ctrl`

## Requirements
- R1: After reset, the control register reads 0, which selects timer triggering with polling. `cnv_start` and `irq` are low, and the completion flag is clear.
- R2: When control bit 0 is 1, a write to the start port gives a `cnv_start` pulse exactly one clock wide. The pulse begins in the cycle after the write.
- R3: Only the selected trigger source has an effect. With control bit 0 at 1, timer edges produce no start pulse. With control bit 0 at 0, start-port writes produce no start pulse.
- R4: With control bit 0 at 0, every rising edge of `tmr_clk` produces exactly one `cnv_start` pulse one clock wide. The pulses therefore repeat at the timer period.
- R5: On each rising edge of the synchronized EOC, the block captures `cnv_data`. A read of the data port returns the captured word in its low bits.
- R6: Status bit 0 is the completion flag. It is set by a rising EOC and cleared by a data-port read. If both happen in the same cycle, the set wins.
- R7: Status bit 1 shows the level of `tmr_clk` after synchronization.
- R8: `irq` is high exactly while the completion flag is set and control bit 1 is 1. It falls once the data port has been read.
- R9: Control bit 0 (start-port trigger) and control bit 1 (interrupt enable) read back as written from the control port. Reads with no strobe return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| sel_ctrl | input | 1 | Decoded select for the control port (read/write) |
| sel_start | input | 1 | Decoded select for the start port (write) |
| sel_status | input | 1 | Decoded select for the status port (read) |
| sel_data | input | 1 | Decoded select for the data port (read) |
| io_wdata | input | BUS_W | Write data |
| io_rdata | output | BUS_W | Read data, valid while io_rd is high |
| cnv_start | output | 1 | Start-of-conversion pulse to the converter |
| cnv_eoc | input | 1 | Converter end of conversion: low while busy, high when done |
| cnv_data | input | DATA_W | Converter output word |
| tmr_clk | input | 1 | Periodic timer clock, asynchronous |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is timer mode, where the processor never starts a conversion and the pulse count and spacing depend on a slow asynchronous clock. The stimulus holds the timer high and low for fixed stretches of 20 cycles. It records the cycle of every start pulse, then checks the pulse count, each pulse width and the gap between pulses. A converter model in the bench answers every start pulse. This lets the flag, the interrupt and the data path be driven in both modes. It also lets the wrong-source stimulus in each mode be shown to give no pulse at all.

// File: rtl/cvi_pkg.sv
package cvi_pkg;
  localparam int CTRL_SW_BIT  = 0;
  localparam int CTRL_IRQ_BIT = 1;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_TMR_BIT  = 1;

  typedef struct packed {
    logic irq_en;
    logic sw_trig;
  } ctrl_t;
endpackage

// File: rtl/cvi_sync.sv
module cvi_sync #(
  parameter int STAGES = 2,
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cvi_trigger.sv
module cvi_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_sel,
  input  logic start_wr,
  input  logic tmr_s,
  output logic start_o
);
  logic tmr_d;
  logic tmr_rise;

  assign tmr_rise = tmr_s & ~tmr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_d   <= 1'b0;
      start_o <= 1'b0;
    end else begin
      tmr_d   <= tmr_s;
      start_o <= sw_sel ? start_wr : tmr_rise;
    end
  end

  // Timer-sourced pulses never last longer than a single clock
  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_sel && $past(!sw_sel) && start_o) |=> !start_o);
endmodule

// File: rtl/cvi_eoc_ctl.sv
module cvi_eoc_ctl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eoc_s,
  input  logic [DATA_W-1:0] cnv_data,
  input  logic              rd_data,
  input  logic              irq_en,
  output logic              done,
  output logic [DATA_W-1:0] sample,
  output logic              irq
);
  logic eoc_d;
  logic eoc_rise;

  assign eoc_rise = eoc_s & ~eoc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_d  <= 1'b0;
      done   <= 1'b0;
      sample <= '0;
    end else begin
      eoc_d <= eoc_s;
      if (eoc_rise) begin
        done   <= 1'b1;
        sample <= cnv_data;
      end else if (rd_data) begin
        done <= 1'b0;
      end
    end
  end

  assign irq = done & irq_en;

  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_rise |=> done);
  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !eoc_rise) |=> !done);
  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_rise |=> (sample == $past(cnv_data)));
endmodule

// File: rtl/cvi_host_ctrl.sv
module cvi_host_ctrl
  import cvi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              sel_ctrl,
  input  logic              sel_start,
  input  logic              sel_status,
  input  logic              sel_data,
  input  logic [BUS_W-1:0]  io_wdata,
  output logic [BUS_W-1:0]  io_rdata,
  output logic              cnv_start,
  input  logic              cnv_eoc,
  input  logic [DATA_W-1:0] cnv_data,
  input  logic              tmr_clk,
  output logic              irq
);
  localparam int PAD_W = BUS_W - DATA_W;

  ctrl_t             ctrl_q;
  logic [1:0]        async_in;
  logic [1:0]        async_s;
  logic              tmr_s;
  logic              eoc_s;
  logic              done;
  logic [DATA_W-1:0] sample;
  logic              rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (io_wr && sel_ctrl) begin
      ctrl_q.sw_trig <= io_wdata[CTRL_SW_BIT];
      ctrl_q.irq_en  <= io_wdata[CTRL_IRQ_BIT];
    end
  end

  assign async_in = {cnv_eoc, tmr_clk};

  cvi_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_in), .q(async_s)
  );
  assign tmr_s = async_s[0];
  assign eoc_s = async_s[1];

  cvi_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .sw_sel(ctrl_q.sw_trig),
    .start_wr(io_wr & sel_start), .tmr_s(tmr_s), .start_o(cnv_start)
  );

  assign rd_data = io_rd & sel_data;

  cvi_eoc_ctl #(.DATA_W(DATA_W)) u_eoc (
    .clk(clk), .rst_n(rst_n), .eoc_s(eoc_s), .cnv_data(cnv_data),
    .rd_data(rd_data), .irq_en(ctrl_q.irq_en), .done(done),
    .sample(sample), .irq(irq)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (sel_ctrl) begin
        io_rdata[CTRL_SW_BIT]  = ctrl_q.sw_trig;
        io_rdata[CTRL_IRQ_BIT] = ctrl_q.irq_en;
      end else if (sel_status) begin
        io_rdata[STAT_DONE_BIT] = done;
        io_rdata[STAT_TMR_BIT]  = tmr_s;
      end else if (sel_data) begin
        io_rdata = {{PAD_W{1'b0}}, sample};
      end
    end
  end

  // A pending request is withdrawn once the flag drops
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> !irq);
endmodule

// File: tb/cvi_host_ctrl_tb.sv
module cvi_host_ctrl_tb;
  localparam int DW = 8;
  localparam int BW = 8;
  localparam int CONV_CYC = 6;

  logic clk = 0, rst_n = 0;
  logic io_wr = 0, io_rd = 0;
  logic sel_ctrl = 0, sel_start = 0, sel_status = 0, sel_data = 0;
  logic [BW-1:0] io_wdata = '0;
  logic [BW-1:0] io_rdata;
  logic cnv_start, irq;
  logic cnv_eoc = 0;
  logic [DW-1:0] cnv_data = '0;
  logic tmr_clk = 0;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int n_starts = 0;
  int max_width = 0, cur_width = 0;
  int last_start_cyc = 0, prev_start_cyc = 0;
  logic [DW-1:0] exp_q[$];
  logic [BW-1:0] rv;

  always #4 clk = ~clk;

  cvi_host_ctrl #(.DATA_W(DW), .BUS_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .sel_ctrl(sel_ctrl), .sel_start(sel_start), .sel_status(sel_status),
    .sel_data(sel_data), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cnv_start(cnv_start), .cnv_eoc(cnv_eoc), .cnv_data(cnv_data),
    .tmr_clk(tmr_clk), .irq(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter model and start monitor: every start is a pushed scoreboard item
  initial begin
    int cnt = 0;
    int busy = 0;
    logic [DW-1:0] nxt = 8'h3C;
    forever begin
      @(negedge clk);
      if (cnv_start) begin
        n_starts++;
        cur_width++;
        if (cur_width > max_width) max_width = cur_width;
        if (cur_width == 1) begin
          prev_start_cyc = last_start_cyc;
          last_start_cyc = cyc;
        end
        cnv_eoc = 0;
        nxt = nxt + 8'd37;
        exp_q.push_back(nxt);
        busy = 1;
        cnt = 0;
      end else begin
        cur_width = 0;
        if (busy != 0) begin
          cnt++;
          if (cnt == CONV_CYC) begin
            cnv_data = exp_q[$];
            cnv_eoc = 1;
            busy = 0;
          end
        end
      end
    end
  end

  task automatic bus_write(input int port, input logic [BW-1:0] d);
    @(negedge clk);
    io_wr = 1; io_wdata = d;
    sel_ctrl = (port == 0); sel_start = (port == 1);
    @(negedge clk);
    io_wr = 0; sel_ctrl = 0; sel_start = 0;
  endtask

  task automatic bus_read(input int port, output logic [BW-1:0] d);
    @(negedge clk);
    io_rd = 1;
    sel_ctrl = (port == 0); sel_status = (port == 2); sel_data = (port == 3);
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 0; sel_ctrl = 0; sel_status = 0; sel_data = 0;
  endtask

  // Monitor side of the scoreboard: pop the newest expected item and compare
  task automatic read_and_score(input string req);
    logic [DW-1:0] e;
    bus_read(3, rv);
    e = exp_q[$];
    exp_q.delete();
    check(req, rv, {{(BW-DW){1'b0}}, e});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 cnv_start", cnv_start, 0);
    check("R1 irq", irq, 0);
    bus_read(0, rv); check("R1 ctrl", rv, 0);
    bus_read(2, rv); check("R1 status", rv, 0);

    // Software trigger, polled
    bus_write(0, 8'h01);
    bus_read(0, rv); check("R9 ctrl readback", rv, 8'h01);
    bus_write(1, 8'h00);
    check("R2 pulse high", cnv_start, 1);
    @(negedge clk);
    check("R2 pulse one cycle", cnv_start, 0);
    wait_cyc(CONV_CYC + 6);
    bus_read(2, rv); check("R6 done set", rv[0], 1);
    check("R8 irq masked", irq, 0);
    read_and_score("R5 data");
    bus_read(2, rv); check("R6 done cleared", rv[0], 0);

    // Software trigger, interrupt
    bus_write(0, 8'h03);
    bus_read(0, rv); check("R9 ctrl readback", rv, 8'h03);
    bus_write(1, 8'h00);
    wait_cyc(CONV_CYC + 6);
    check("R8 irq raised", irq, 1);
    read_and_score("R5 data irq mode");
    @(negedge clk);
    check("R8 irq dropped", irq, 0);

    // Timer edges ignored in software mode; level visible in status
    s0 = n_starts;
    repeat (3) begin
      tmr_clk = 1; wait_cyc(6);
      tmr_clk = 0; wait_cyc(6);
    end
    check("R3 timer ignored", n_starts - s0, 0);
    tmr_clk = 1; wait_cyc(4);
    bus_read(2, rv); check("R7 tmr high", rv[1], 1);
    tmr_clk = 0; wait_cyc(4);
    bus_read(2, rv); check("R7 tmr low", rv[1], 0);

    // Timer mode with interrupt: start port ignored
    bus_write(0, 8'h02);
    s0 = n_starts;
    bus_write(1, 8'h00);
    wait_cyc(4);
    check("R3 start port ignored", n_starts - s0, 0);
    max_width = 0;
    repeat (4) begin
      tmr_clk = 1; wait_cyc(20);
      tmr_clk = 0; wait_cyc(20);
    end
    check("R4 pulse count", n_starts - s0, 4);
    check("R4 pulse width", max_width, 1);
    check("R4 pulse spacing", last_start_cyc - prev_start_cyc, 40);
    check("R8 irq timer mode", irq, 1);
    read_and_score("R5 data timer mode");
    bus_read(2, rv); check("R6 done cleared timer", rv[0], 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #800000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule